// File: doc/BRIEF.md
# Branch History Table Predictor

This block sits beside the instruction fetch stage and predicts, within the fetch cycle, whether the instruction at the current fetch address is a taken branch and where fetch should go next. It holds a small direct-mapped table. Each slot keeps an address tag, a two-bit hysteresis counter and the last known target of the branch that owns the slot. When the fetch address finds no matching slot, the block predicts not-taken and points fetch at the next sequential word.

The execute stage reports each resolved branch on an update stream: the branch address, whether it was taken, and its target. The stream uses valid/ready. `upd_ready` is low only while reset is asserted. After reset it stays high, so the execute stage never sees back-pressure once the block is running. A record transfers on a rising clock edge where both `upd_valid` and `upd_ready` are high. The lookup side is a plain combinational query qualified by `fetch_valid`.

With the default `ENTRIES = 16` and `ADDR_W = 32`:
- The slot index is address bits [5:2].
- The tag is address bits [31:6].
- Address bits [1:0] are not used for matching.

Top module: `bht_predictor`

## Requirements
- R1: After reset every slot is empty, so a lookup at any address reports `pred_hit = 0`.
- R2: When a lookup does not hit, `pred_taken = 0` and `pred_next_pc = fetch_pc + 4`.
- R3: A slot is chosen by address bits [5:2]. A lookup hits only when the stored tag equals address bits [31:6]. An address that shares the index but differs in those upper bits therefore misses.
- R4: A resolved taken branch that misses in the table writes its slot with the new tag and its target, replacing any occupant. The counter starts in weak-taken, so the next lookup hits and predicts taken to that target.
- R5: A resolved not-taken branch that misses leaves the table unchanged. A later lookup at that address still misses.
- R6: On a hit, the counter moves through four states: strong-not-taken, weak-not-taken, weak-taken, strong-taken.
  - A taken outcome moves it one step toward strong-taken.
  - A not-taken outcome moves it one step toward strong-not-taken.
  - Both ends saturate.
  - The prediction is taken in the two taken states, so a taken prediction survives a single not-taken outcome.
  - As a result, a loop branch re-entered after one exit is still predicted taken.
- R7: A taken outcome that hits replaces the stored target with the reported one. A not-taken outcome that hits keeps the stored target.
- R8: Lookup is combinational. An update transferred on a clock edge is not visible to a lookup before that edge and is visible immediately after it.
- R9: While `fetch_valid = 0`, `pred_hit` and `pred_taken` are 0.
- R10: `upd_ready` is 0 while `rst` is high and 1 otherwise.
- R11: When a lookup hits and predicts taken, `pred_next_pc` equals the stored target. When it hits and predicts not-taken, `pred_next_pc` equals `fetch_pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch address is meaningful this cycle |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | A slot matches the fetch address |
| pred_taken | output | 1 | Predicted taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | Resolved-branch record offered |
| upd_ready | output | 1 | Block accepts a record |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench walks one slot through the full counter ladder and checks it at both saturating ends. A counter that flips on a single not-taken outcome, or that wraps past an end, would show up as a wrong prediction in that walk. It runs a loop branch twice and expects only the exit to be mispredicted on the second pass; a last-outcome design would also miss the entry. It sets up aliasing between two addresses with the same index, which exposes a tag compare that is too narrow, and sends a not-taken record for an address that misses, which exposes a spurious allocation. It also drives an update and a lookup to the same slot in one cycle, checking that the write is not bypassed into the current lookup and is not delayed by an extra cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;

  // Two-bit hysteresis counter; the upper bit is the prediction.
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bht_addr_split.sv
module bht_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  // Word-aligned: byte offset bits take no part in matching.
  logic unused_byte_ofs;
  assign unused_byte_ofs = ^addr[1:0];
  assign idx = addr[IDX_W+1:2];
  assign tag = addr[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  ctr_t              wr_ctr,
  input  logic [ADDR_W-1:0] wr_target,
  // read port A (fetch side)
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output ctr_t              ra_ctr,
  output logic [ADDR_W-1:0] ra_target,
  // read port B (update side)
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output ctr_t              rb_ctr,
  output logic [ADDR_W-1:0] rb_target
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  ctr_t               ctr_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];

  // Only the valid bits need a reset; payload is qualified by them.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx]  <= 1'b1;
      tag_q[wr_idx]    <= wr_tag;
      ctr_q[wr_idx]    <= wr_ctr;
      target_q[wr_idx] <= wr_target;
    end
  end

  assign ra_valid  = valid_q[ra_idx];
  assign ra_tag    = tag_q[ra_idx];
  assign ra_ctr    = ctr_q[ra_idx];
  assign ra_target = target_q[ra_idx];

  assign rb_valid  = valid_q[rb_idx];
  assign rb_tag    = tag_q[rb_idx];
  assign rb_ctr    = ctr_q[rb_idx];
  assign rb_target = target_q[rb_idx];
endmodule

// File: rtl/bht_update_ctl.sv
module bht_update_ctl
  import bht_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26
) (
  input  logic              fire,
  input  logic              res_taken,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              cur_valid,
  input  logic [TAG_W-1:0]  cur_tag,
  input  ctr_t              cur_ctr,
  input  logic [ADDR_W-1:0] cur_target,
  output logic              wr_en,
  output ctr_t              wr_ctr,
  output logic [ADDR_W-1:0] wr_target
);
  logic owns_slot;
  assign owns_slot = cur_valid && (cur_tag == res_tag);

  always_comb begin
    wr_en     = 1'b0;
    wr_ctr    = CTR_WT;
    wr_target = res_target;
    if (fire) begin
      if (owns_slot) begin
        // train the existing entry
        wr_en     = 1'b1;
        wr_ctr    = ctr_step(cur_ctr, res_taken);
        wr_target = res_taken ? res_target : cur_target;
      end else if (res_taken) begin
        // allocate on a taken miss, evicting any occupant
        wr_en     = 1'b1;
        wr_ctr    = CTR_WT;
        wr_target = res_target;
      end
    end
  end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  ctr_t              a_ctr, b_ctr;
  logic [ADDR_W-1:0] a_target, b_target;
  logic              wr_en;
  ctr_t              wr_ctr;
  logic [ADDR_W-1:0] wr_target;
  logic              upd_fire;

  bht_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fetch_split_i (
    .addr(fetch_pc), .idx(f_idx), .tag(f_tag));

  bht_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) upd_split_i (
    .addr(upd_pc), .idx(u_idx), .tag(u_tag));

  bht_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_ctr(wr_ctr),
    .wr_target(wr_target),
    .ra_idx(f_idx), .ra_valid(a_valid), .ra_tag(a_tag), .ra_ctr(a_ctr),
    .ra_target(a_target),
    .rb_idx(u_idx), .rb_valid(b_valid), .rb_tag(b_tag), .rb_ctr(b_ctr),
    .rb_target(b_target));

  bht_update_ctl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) upd_ctl_i (
    .fire(upd_fire), .res_taken(upd_taken), .res_tag(u_tag),
    .res_target(upd_target),
    .cur_valid(b_valid), .cur_tag(b_tag), .cur_ctr(b_ctr),
    .cur_target(b_target),
    .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_target(wr_target));

  // update stream: no back-pressure outside reset
  assign upd_ready = !rst;
  assign upd_fire  = upd_valid && upd_ready;

  // fetch-side lookup, same cycle
  assign pred_hit     = fetch_valid && a_valid && (a_tag == f_tag);
  assign pred_taken   = pred_hit && ctr_says_taken(a_ctr);
  assign pred_next_pc = pred_taken ? a_target : (fetch_pc + WORD_STEP);
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);
  // R2
  miss_sequential_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (!pred_taken && pred_next_pc == fetch_pc + ADDR_W'(4)));

  // R9
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> (!pred_hit && !pred_taken));

  // R10
  ready_in_reset_chk: assert property (@(posedge clk)
    rst |-> !upd_ready);

  // R10
  ready_running_chk: assert property (@(posedge clk) disable iff (rst)
    upd_ready);

  // R4
  taken_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_ready && upd_taken) |=>
      (!(fetch_valid && fetch_pc[ADDR_W-1:2] == $past(upd_pc[ADDR_W-1:2]))
       || pred_hit));

  // R7
  taken_target_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_ready && upd_taken) |=>
      (!(fetch_valid && pred_taken &&
         fetch_pc[ADDR_W-1:2] == $past(upd_pc[ADDR_W-1:2]))
       || pred_next_pc == $past(upd_target)));
endmodule

bind bht_predictor bht_predictor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
  .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target));

// File: tb/bht_predictor_tb_top.sv
`timescale 1ns/1ps
module bht_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bht_predictor #(.ENTRIES(16), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive a lookup at a falling edge and settle
  task automatic look(input logic [31:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    #2;
  endtask

  task automatic expect_pred(input logic [31:0] pc, input bit hit, input bit tk,
                             input logic [31:0] nxt, input string req);
    look(pc);
    check(pred_hit == hit, req, "hit", {31'd0, pred_hit}, {31'd0, hit});
    check(pred_taken == tk, req, "taken", {31'd0, pred_taken}, {31'd0, tk});
    check(pred_next_pc == nxt, req, "next_pc", pred_next_pc, nxt);
  endtask

  task automatic send_update(input logic [31:0] pc, input bit tk,
                             input logic [31:0] tgt);
    @(negedge clk);
    upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_valid = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(upd_ready == 1'b0, "R10", "ready in reset", {31'd0, upd_ready}, 32'd0);
    @(negedge clk); rst = 1'b0;
    #2;
    check(upd_ready == 1'b1, "R10", "ready after reset", {31'd0, upd_ready}, 32'd1);
    expect_pred(32'h0000_1008, 0, 0, 32'h0000_100C, "R1");
    expect_pred(32'h0000_2F3C, 0, 0, 32'h0000_2F40, "R2");
  endtask

  task automatic t_no_alloc_nt;
    send_update(32'h0000_6004, 1'b0, 32'h0000_7000);
    expect_pred(32'h0000_6004, 0, 0, 32'h0000_6008, "R5");
  endtask

  task automatic t_alloc;
    send_update(32'h0000_1008, 1'b1, 32'h0000_2000);
    expect_pred(32'h0000_1008, 1, 1, 32'h0000_2000, "R4");
    // weak taken: one not-taken flips prediction
    send_update(32'h0000_1008, 1'b0, 32'h0000_1234);
    expect_pred(32'h0000_1008, 1, 0, 32'h0000_100C, "R4");
  endtask

  task automatic t_ladder;
    logic [31:0] c = 32'h0000_3010;
    send_update(c, 1, 32'h0000_3800);             // alloc WT
    send_update(c, 1, 32'h0000_3800);             // ST
    send_update(c, 1, 32'h0000_3800);             // ST saturates
    send_update(c, 0, 32'h0);                     // WT
    expect_pred(c, 1, 1, 32'h0000_3800, "R6");
    send_update(c, 0, 32'h0);                     // WNT
    expect_pred(c, 1, 0, 32'h0000_3014, "R11");
    send_update(c, 0, 32'h0);                     // SNT
    send_update(c, 0, 32'h0);                     // SNT saturates
    send_update(c, 1, 32'h0000_3900);             // WNT
    expect_pred(c, 1, 0, 32'h0000_3014, "R6");
    send_update(c, 1, 32'h0000_3900);             // WT
    expect_pred(c, 1, 1, 32'h0000_3900, "R6");
  endtask

  task automatic t_loop;
    logic [31:0] lp = 32'h0000_5030;
    logic [31:0] top = 32'h0000_5000;
    int miss_pass2 = 0;
    bit first_pred = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int it = 0; it < 5; it++) begin
        bit outcome = (it < 4);
        look(lp);
        if (pass == 1 && it == 0) first_pred = pred_taken;
        if (pass == 1 && pred_taken != outcome) miss_pass2++;
        send_update(lp, outcome, top);
      end
    end
    check(first_pred == 1'b1, "R6", "loop re-entry predicted taken",
          {31'd0, first_pred}, 32'd1);
    check(miss_pass2 == 1, "R6", "mispredicts on second pass",
          32'(miss_pass2), 32'd1);
  endtask

  task automatic t_alias;
    // 0x1008 and 0x1048 share index 2, different tag
    expect_pred(32'h0000_1048, 0, 0, 32'h0000_104C, "R3");
    expect_pred(32'h0000_100B, 1, 0, 32'h0000_100F, "R3");
    send_update(32'h0000_1048, 1, 32'h0000_9000);
    expect_pred(32'h0000_1048, 1, 1, 32'h0000_9000, "R4");
    expect_pred(32'h0000_1008, 0, 0, 32'h0000_100C, "R3");
  endtask

  task automatic t_target;
    send_update(32'h0000_1048, 1, 32'h0000_9400);
    expect_pred(32'h0000_1048, 1, 1, 32'h0000_9400, "R7");
    send_update(32'h0000_1048, 1, 32'h0000_9400); // ST
    send_update(32'h0000_1048, 0, 32'h0000_AAAA); // WT, target kept
    expect_pred(32'h0000_1048, 1, 1, 32'h0000_9400, "R7");
  endtask

  task automatic t_same_cycle;
    logic [31:0] p = 32'h0000_8018;
    @(negedge clk);
    fetch_valid = 1; fetch_pc = p;
    upd_pc = p; upd_taken = 1; upd_target = 32'h0000_8800; upd_valid = 1;
    #2;
    check(pred_hit == 1'b0, "R8", "before edge", {31'd0, pred_hit}, 32'd0);
    @(posedge clk);
    #1 upd_valid = 0;
    #1;
    check(pred_hit == 1'b1, "R8", "after edge hit", {31'd0, pred_hit}, 32'd1);
    check(pred_next_pc == 32'h0000_8800, "R8", "after edge next",
          pred_next_pc, 32'h0000_8800);
  endtask

  task automatic t_idle;
    @(negedge clk);
    fetch_valid = 0; fetch_pc = 32'h0000_8018;
    #2;
    check(pred_hit == 1'b0 && pred_taken == 1'b0, "R9", "hit/taken idle",
          {30'd0, pred_hit, pred_taken}, 32'd0);
    check(pred_next_pc == 32'h0000_801C, "R9", "next idle",
          pred_next_pc, 32'h0000_801C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_no_alloc_nt;
    t_alloc;
    t_ladder;
    t_loop;
    t_alias;
    t_target;
    t_same_cycle;
    t_idle;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule